// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoint

This block keeps, for every architectural register of an out-of-order core, either its committed-ready value or the tag of the operation that will produce it. Each cycle one instruction of up to two operations (A then B) may enter. The four source operands of the instruction are looked up in the same cycle. Each enabled destination is given a fresh tag by an internal allocator, and the register's entry is marked pending under that tag. Finished results come back on several distribution buses. A bus whose tag matches a pending entry makes that entry ready and stores the value.

Every entry has two copies: the working map and a shadow. When an instruction that carries a conditional branch is accepted, the shadow of every register takes a copy of the working map in the same cycle. The copy includes the branch instruction's own renames. Distribution buses update both copies. A mispredicted branch can therefore restore the whole working map from the shadow in one cycle. Only one branch may be outstanding. A second branch stalls until the first is resolved. Register 12 is a sibling-forwarding register and is never renamed.

Top module: `alias_map`

## Requirements
- R1: After reset every entry reads as ready with value zero.
- R2: Tags are handed out from 1 upward, one per enabled destination of an accepted instruction. Operation A is served before operation B. Tag 0 is never used, and after the all-ones tag the next tag is 1. From the next cycle on, a renamed register reads as not ready with its new tag.
- R3: A lookup returns ready=1 with the value, or ready=0 with the producer tag. It shows the map as it stood before the destinations of the instruction presented in that cycle.
- R4: A valid distribution bus whose tag equals the tag of a pending entry makes the entry ready with the bus value. This applies to the working copy and the shadow copy alike.
- R5: When a distribution bus matches the pending register being looked up, in the same cycle, the lookup returns ready with the bus value.
- R6: A distribution bus has no effect on an entry that is already ready, even when its tag equals the entry's old tag.
- R7: When both operations write the same register, the entry keeps operation B's tag.
- R8: A destination of register 12 consumes a tag but leaves the entry of register 12 unchanged.
- R9: Accepting an instruction that carries a branch copies the updated working map into the shadow and marks a branch as pending.
- R10: While a branch is pending, a further branch instruction is stalled (ren_stall=1). A stalled instruction changes no entry and takes no tag.
- R11: A resolve flagged as a miss, while a branch is pending, replaces the working map with the shadow in one cycle and clears the pending branch. In that cycle any instruction is stalled.
- R12: A resolve flagged as a hit clears the pending branch and leaves the working map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented |
| ren_is_branch | input | 1 | The instruction carries a conditional branch |
| dst_a_en | input | 1 | Operation A writes a register |
| dst_a_idx | input | 4 | Destination register of operation A |
| dst_b_en | input | 1 | Operation B writes a register |
| dst_b_idx | input | 4 | Destination register of operation B |
| ren_stall | output | 1 | The instruction is not accepted this cycle |
| dst_a_tag | output | 5 | Tag assigned to operation A |
| dst_b_tag | output | 5 | Tag assigned to operation B |
| lk_idx | input | 16 | Four source register indices, lane n in bits 4n+3:4n |
| lk_ready | output | 4 | Per-lane ready flag |
| lk_tag | output | 20 | Per-lane producer tag, lane n in bits 5n+4:5n |
| lk_value | output | 128 | Per-lane value, lane n in bits 32n+31:32n |
| dist_valid | input | 2 | Distribution bus valid flags |
| dist_tag | input | 10 | Distribution bus tags, bus n in bits 5n+4:5n |
| dist_value | input | 64 | Distribution bus values, bus n in bits 32n+31:32n |
| resolve_valid | input | 1 | The pending branch is resolved this cycle |
| resolve_miss | input | 1 | The resolved prediction was wrong |

## Verification
The assertions check the branch bookkeeping on every cycle. They cover the stall of a second branch while one is pending, that at most one checkpoint is outstanding, and that both kinds of resolve clear the pending state. They also check that allocated tags are never zero and never duplicated within an instruction, and that lane 0 never reports pending while a bus carries its tag. The contents of the map can only be shown by the bench's scenarios: the restore of entries renamed after the branch, the shadow picking up results during the pending window, the way stale buses are ignored, the winner when both operations write one register, the order of tags and their wraparound, and the fixed register 12.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 5;

  typedef struct packed {
    logic              ready;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] value;
  } map_ent_t;

  // successor tag, skipping the reserved zero tag
  function automatic logic [TAG_W-1:0] tag_succ(input logic [TAG_W-1:0] t);
    return (t == {TAG_W{1'b1}}) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  // a bus only lands on a pending entry carrying the same tag
  function automatic logic bus_hits(input map_ent_t e, input logic v,
                                    input logic [TAG_W-1:0] t);
    return v && !e.ready && (e.tag == t);
  endfunction
endpackage

// File: rtl/alias_tag_alloc.sv
module alias_tag_alloc
  import alias_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_a,
  input  logic             take_b,
  output logic [TAG_W-1:0] tag_a,
  output logic [TAG_W-1:0] tag_b
);
  logic [TAG_W-1:0] next_q;
  logic [TAG_W-1:0] after_a;
  logic [TAG_W-1:0] after_b;

  always_comb begin
    after_a = take_a ? tag_succ(next_q) : next_q;
    after_b = take_b ? tag_succ(after_a) : after_a;
    tag_a   = next_q;
    tag_b   = after_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) next_q <= TAG_W'(1);
    else        next_q <= after_b;
  end
endmodule

// File: rtl/alias_entry.sv
module alias_entry
  import alias_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_wr,
  input  logic [TAG_W-1:0]          ren_tag,
  input  logic                      take_ckpt,
  input  logic                      do_restore,
  input  logic [NUM_BUS-1:0]        dist_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  dist_tag,
  input  logic [NUM_BUS*DATA_W-1:0] dist_value,
  output map_ent_t                  cur_o,
  output map_ent_t                  bak_o
);
  map_ent_t cur_q, bak_q;
  map_ent_t cur_abs, bak_abs;
  map_ent_t cur_nx, bak_nx;

  // absorb results into both copies
  always_comb begin
    cur_abs = cur_q;
    bak_abs = bak_q;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (bus_hits(cur_abs, dist_valid[b], dist_tag[b*TAG_W +: TAG_W])) begin
        cur_abs.ready = 1'b1;
        cur_abs.value = dist_value[b*DATA_W +: DATA_W];
      end
      if (bus_hits(bak_abs, dist_valid[b], dist_tag[b*TAG_W +: TAG_W])) begin
        bak_abs.ready = 1'b1;
        bak_abs.value = dist_value[b*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    if (do_restore) begin
      cur_nx = bak_abs;
    end else if (ren_wr) begin
      cur_nx       = cur_abs;
      cur_nx.ready = 1'b0;
      cur_nx.tag   = ren_tag;
    end else begin
      cur_nx = cur_abs;
    end
    bak_nx = take_ckpt ? cur_nx : bak_abs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '{ready: 1'b1, tag: '0, value: '0};
      bak_q <= '{ready: 1'b1, tag: '0, value: '0};
    end else begin
      cur_q <= cur_nx;
      bak_q <= bak_nx;
    end
  end

  assign cur_o = cur_q;
  assign bak_o = bak_q;
endmodule

// File: rtl/alias_port.sv
module alias_port
  import alias_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_BUS  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]          idx,
  input  map_ent_t                  map_i [NUM_REGS],
  input  logic [NUM_BUS-1:0]        dist_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  dist_tag,
  input  logic [NUM_BUS*DATA_W-1:0] dist_value,
  output logic                      ready,
  output logic [TAG_W-1:0]          tag,
  output logic [DATA_W-1:0]         value
);
  map_ent_t sel;

  always_comb begin
    sel   = map_i[idx];
    ready = sel.ready;
    tag   = sel.tag;
    value = sel.value;
    // same-cycle result bypass
    for (int b = 0; b < NUM_BUS; b++) begin
      if (bus_hits(sel, dist_valid[b], dist_tag[b*TAG_W +: TAG_W])) begin
        ready = 1'b1;
        value = dist_value[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/alias_map.sv
module alias_map
  import alias_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_BUS  = 2,
  parameter int LANES    = 4,
  parameter int FWD_REG  = 12,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_valid,
  input  logic                      ren_is_branch,
  input  logic                      dst_a_en,
  input  logic [IDX_W-1:0]          dst_a_idx,
  input  logic                      dst_b_en,
  input  logic [IDX_W-1:0]          dst_b_idx,
  output logic                      ren_stall,
  output logic [TAG_W-1:0]          dst_a_tag,
  output logic [TAG_W-1:0]          dst_b_tag,
  input  logic [LANES*IDX_W-1:0]    lk_idx,
  output logic [LANES-1:0]          lk_ready,
  output logic [LANES*TAG_W-1:0]    lk_tag,
  output logic [LANES*DATA_W-1:0]   lk_value,
  input  logic [NUM_BUS-1:0]        dist_valid,
  input  logic [NUM_BUS*TAG_W-1:0]  dist_tag,
  input  logic [NUM_BUS*DATA_W-1:0] dist_value,
  input  logic                      resolve_valid,
  input  logic                      resolve_miss
);
  // named internal events
  logic pending_q;
  logic ren_accept;
  logic take_ckpt;
  logic do_restore;
  logic do_confirm;
  logic alloc_a, alloc_b;

  map_ent_t cur_map [NUM_REGS];
  map_ent_t bak_map [NUM_REGS];

  assign do_restore = resolve_valid && resolve_miss && pending_q;
  assign do_confirm = resolve_valid && !resolve_miss && pending_q;
  assign ren_stall  = (ren_is_branch && pending_q) || do_restore;
  assign ren_accept = ren_valid && !ren_stall;
  assign take_ckpt  = ren_accept && ren_is_branch;
  assign alloc_a    = ren_accept && dst_a_en;
  assign alloc_b    = ren_accept && dst_b_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                       pending_q <= 1'b0;
    else if (take_ckpt)               pending_q <= 1'b1;
    else if (do_restore || do_confirm) pending_q <= 1'b0;
  end

  alias_tag_alloc u_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_a (alloc_a),
    .take_b (alloc_b),
    .tag_a  (dst_a_tag),
    .tag_b  (dst_b_tag)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic             hit_a, hit_b, wr;
    logic [TAG_W-1:0] wr_tag;
    assign hit_a = alloc_a && (dst_a_idx == IDX_W'(r));
    assign hit_b = alloc_b && (dst_b_idx == IDX_W'(r));
    if (r == FWD_REG) begin : g_fixed
      assign wr = 1'b0;
    end else begin : g_renamed
      assign wr = hit_a || hit_b;
    end
    // B is the later operation and wins
    assign wr_tag = hit_b ? dst_b_tag : dst_a_tag;

    alias_entry #(.NUM_BUS(NUM_BUS)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .ren_wr     (wr),
      .ren_tag    (wr_tag),
      .take_ckpt  (take_ckpt),
      .do_restore (do_restore),
      .dist_valid (dist_valid),
      .dist_tag   (dist_tag),
      .dist_value (dist_value),
      .cur_o      (cur_map[r]),
      .bak_o      (bak_map[r])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    alias_port #(.NUM_REGS(NUM_REGS), .NUM_BUS(NUM_BUS)) u_port (
      .idx        (lk_idx[l*IDX_W +: IDX_W]),
      .map_i      (cur_map),
      .dist_valid (dist_valid),
      .dist_tag   (dist_tag),
      .dist_value (dist_value),
      .ready      (lk_ready[l]),
      .tag        (lk_tag[l*TAG_W +: TAG_W]),
      .value      (lk_value[l*DATA_W +: DATA_W])
    );
  end

  // shadow copy is read only through restore
  logic bak_seen;
  always_comb begin
    bak_seen = 1'b0;
    for (int r = 0; r < NUM_REGS; r++) bak_seen = bak_seen ^ bak_map[r].ready;
  end
  logic unused_ok;
  assign unused_ok = bak_seen;
endmodule

// File: rtl/alias_map_chk.sv
module alias_map_chk
  import alias_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ren_valid,
  input logic                     ren_is_branch,
  input logic                     ren_stall,
  input logic                     pending_q,
  input logic                     take_ckpt,
  input logic                     do_restore,
  input logic                     do_confirm,
  input logic                     alloc_a,
  input logic                     alloc_b,
  input logic [TAG_W-1:0]         dst_a_tag,
  input logic [TAG_W-1:0]         dst_b_tag,
  input logic                     lk_ready0,
  input logic [TAG_W-1:0]         lk_tag0,
  input logic [NUM_BUS-1:0]       dist_valid,
  input logic [NUM_BUS*TAG_W-1:0] dist_tag
);
  // R10
  stall_second_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_is_branch && pending_q) |-> ren_stall);
  // R9
  single_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !take_ckpt);
  // R9
  ckpt_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ckpt |=> pending_q);
  // R11
  restore_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> !pending_q);
  // R11
  restore_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |-> ren_stall);
  // R12
  confirm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_confirm |=> !pending_q);
  // R2
  tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_a |-> dst_a_tag != '0);
  // R2
  tag_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_a && alloc_b) |-> (dst_a_tag != dst_b_tag) && (dst_b_tag != '0));
  // R5
  bypass_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_ready0 && dist_valid[0]) |-> dist_tag[TAG_W-1:0] != lk_tag0);
endmodule

bind alias_map alias_map_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ren_valid     (ren_valid),
  .ren_is_branch (ren_is_branch),
  .ren_stall     (ren_stall),
  .pending_q     (pending_q),
  .take_ckpt     (take_ckpt),
  .do_restore    (do_restore),
  .do_confirm    (do_confirm),
  .alloc_a       (alloc_a),
  .alloc_b       (alloc_b),
  .dst_a_tag     (dst_a_tag),
  .dst_b_tag     (dst_b_tag),
  .lk_ready0     (lk_ready[0]),
  .lk_tag0       (lk_tag[alias_pkg::TAG_W-1:0]),
  .dist_valid    (dist_valid),
  .dist_tag      (dist_tag)
);

// File: tb/test_alias_map.sv
module test_alias_map;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, ren_is_branch, dst_a_en, dst_b_en;
  logic [3:0] dst_a_idx, dst_b_idx;
  logic ren_stall;
  logic [TW-1:0] dst_a_tag, dst_b_tag;
  logic [15:0] lk_idx;
  logic [3:0] lk_ready;
  logic [19:0] lk_tag;
  logic [127:0] lk_value;
  logic [1:0] dist_valid;
  logic [9:0] dist_tag;
  logic [63:0] dist_value;
  logic resolve_valid, resolve_miss;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_map i_alias_map (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_is_branch(ren_is_branch),
    .dst_a_en(dst_a_en), .dst_a_idx(dst_a_idx), .dst_b_en(dst_b_en), .dst_b_idx(dst_b_idx),
    .ren_stall(ren_stall), .dst_a_tag(dst_a_tag), .dst_b_tag(dst_b_tag),
    .lk_idx(lk_idx), .lk_ready(lk_ready), .lk_tag(lk_tag), .lk_value(lk_value),
    .dist_valid(dist_valid), .dist_tag(dist_tag), .dist_value(dist_value),
    .resolve_valid(resolve_valid), .resolve_miss(resolve_miss)
  );

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired got=%0d expected<20000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_is_branch = 0; dst_a_en = 0; dst_b_en = 0;
    dst_a_idx = 0; dst_b_idx = 0; dist_valid = 0; dist_tag = 0; dist_value = 0;
    resolve_valid = 0; resolve_miss = 0;
  endtask

  // advance one edge, then let inputs settle away from it
  task automatic step();
    @(posedge clk); #1; idle(); #1;
  endtask

  task automatic look(input int lane, input logic [3:0] r);
    lk_idx[lane*4 +: 4] = r; #1;
  endtask

  task automatic expect_ready(input string req, input int lane, input logic [31:0] v);
    check(req, 32'(lk_ready[lane]), 32'd1);
    check(req, lk_value[lane*DW +: DW], v);
  endtask

  task automatic expect_pend(input string req, input int lane, input logic [TW-1:0] t);
    check(req, 32'(lk_ready[lane]), 32'd0);
    check(req, 32'(lk_tag[lane*TW +: TW]), 32'(t));
  endtask

  task automatic issue(input logic br, input logic ae, input logic [3:0] ai,
                       input logic be, input logic [3:0] bi);
    ren_valid = 1; ren_is_branch = br; dst_a_en = ae; dst_a_idx = ai;
    dst_b_en = be; dst_b_idx = bi; #1;
  endtask

  task automatic t_reset();
    for (int r = 0; r < 4; r++) look(r, 4'(r * 5));
    for (int l = 0; l < 4; l++) expect_ready("R1 reset ready", l, 32'h0);
  endtask

  task automatic t_rename();
    issue(0, 1, 4'd3, 1, 4'd5);
    check("R2 first tag A", 32'(dst_a_tag), 32'd1);
    check("R2 tag B after A", 32'(dst_b_tag), 32'd2);
    check("R2 accepted", 32'(ren_stall), 32'd0);
    step();
    look(0, 4'd3); look(1, 4'd5);
    expect_pend("R2 r3 pending", 0, 5'd1);
    expect_pend("R3 r5 pending tag", 1, 5'd2);
  endtask

  task automatic t_dist();
    look(0, 4'd3);
    dist_valid = 2'b01; dist_tag = {5'd0, 5'd1}; dist_value = {32'h0, 32'h0000_AAAA}; #1;
    expect_ready("R5 bypass", 0, 32'h0000_AAAA);
    step();
    look(0, 4'd3); look(1, 4'd5);
    expect_ready("R4 captured", 0, 32'h0000_AAAA);
    expect_pend("R4 other unchanged", 1, 5'd2);
    // second bus delivers r5
    dist_valid = 2'b10; dist_tag = {5'd2, 5'd0}; dist_value = {32'h0000_BBBB, 32'h0};
    step();
    look(1, 4'd5);
    expect_ready("R4 bus1 captured", 1, 32'h0000_BBBB);
  endtask

  task automatic t_stale();
    look(0, 4'd3);
    dist_valid = 2'b01; dist_tag = {5'd0, 5'd1}; dist_value = {32'h0, 32'h0000_5555}; #1;
    expect_ready("R6 no bypass on ready", 0, 32'h0000_AAAA);
    step();
    look(0, 4'd3);
    expect_ready("R6 stale bus ignored", 0, 32'h0000_AAAA);
  endtask

  task automatic t_same();
    look(2, 4'd7);
    issue(0, 1, 4'd7, 1, 4'd7);
    expect_ready("R3 lookup sees old map", 2, 32'h0);
    check("R7 tag A", 32'(dst_a_tag), 32'd3);
    check("R7 tag B", 32'(dst_b_tag), 32'd4);
    step();
    look(2, 4'd7);
    expect_pend("R7 later op wins", 2, 5'd4);
  endtask

  task automatic t_fwd();
    issue(0, 1, 4'd12, 0, 4'd0);
    check("R8 tag consumed", 32'(dst_a_tag), 32'd5);
    step();
    look(3, 4'd12);
    expect_ready("R8 r12 not renamed", 3, 32'h0);
  endtask

  task automatic t_miss();
    issue(1, 1, 4'd1, 0, 4'd0);          // branch, r1 <- tag 6
    check("R9 branch tag", 32'(dst_a_tag), 32'd6);
    check("R9 first branch accepted", 32'(ren_stall), 32'd0);
    step();
    issue(0, 1, 4'd3, 0, 4'd0);          // r3 <- tag 7 after branch
    check("R2 tag after branch", 32'(dst_a_tag), 32'd7);
    step();
    issue(1, 1, 4'd9, 0, 4'd0);          // second branch stalls
    check("R10 second branch stalled", 32'(ren_stall), 32'd1);
    step();
    look(0, 4'd9); look(1, 4'd3);
    expect_ready("R10 stalled instr no change", 0, 32'h0);
    expect_pend("R9 post-branch rename", 1, 5'd7);
    dist_valid = 2'b01; dist_tag = {5'd0, 5'd6}; dist_value = {32'h0, 32'h0000_1111};
    step();
    resolve_valid = 1; resolve_miss = 1; ren_valid = 1; dst_a_en = 1; dst_a_idx = 4'd8; #1;
    check("R11 stall in repair", 32'(ren_stall), 32'd1);
    step();
    look(0, 4'd3); look(1, 4'd1); look(2, 4'd9); look(3, 4'd8);
    expect_ready("R11 r3 restored", 0, 32'h0000_AAAA);
    expect_ready("R4 shadow got result", 1, 32'h0000_1111);
    expect_ready("R11 r9 untouched", 2, 32'h0);
    expect_ready("R11 repair-cycle instr dropped", 3, 32'h0);
  endtask

  task automatic t_hit();
    issue(1, 1, 4'd2, 0, 4'd0);
    check("R10 stalled instr took no tag", 32'(dst_a_tag), 32'd8);
    check("R11 pending cleared", 32'(ren_stall), 32'd0);
    step();
    issue(0, 1, 4'd4, 0, 4'd0);
    check("R2 tag 9", 32'(dst_a_tag), 32'd9);
    step();
    resolve_valid = 1; resolve_miss = 0;
    step();
    look(0, 4'd4); look(1, 4'd2);
    expect_pend("R12 map kept", 0, 5'd9);
    expect_pend("R12 branch dest kept", 1, 5'd8);
    issue(1, 1, 4'd6, 0, 4'd0);
    check("R12 next branch accepted", 32'(ren_stall), 32'd0);
    check("R12 next branch tag", 32'(dst_a_tag), 32'd10);
    step();
    resolve_valid = 1; resolve_miss = 1;
    step();
    look(0, 4'd6);
    expect_pend("R9 branch own rename in shadow", 0, 5'd10);
  endtask

  task automatic t_wrap();
    for (int t = 11; t <= 31; t++) begin
      issue(0, 1, 4'd0, 0, 4'd0);
      step();
    end
    issue(0, 1, 4'd0, 1, 4'd11);
    check("R2 wrap skips zero A", 32'(dst_a_tag), 32'd1);
    check("R2 wrap B", 32'(dst_b_tag), 32'd2);
    step();
    look(0, 4'd0);
    expect_pend("R2 wrapped tag stored", 0, 5'd1);
  endtask

  initial begin
    idle();
    lk_idx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    t_reset();
    t_rename();
    t_dist();
    t_stale();
    t_same();
    t_fwd();
    t_miss();
    t_hit();
    t_wrap();
    summary_and_end();
  end
endmodule